// File: doc/BRIEF.md
# Directory Queue Lock Manager

This block sits at the home node of one lock variable and arbitrates ownership among the nodes of the machine. Nodes do not spin on a shared copy of the lock. Each node sends one acquire message carrying its node number and then waits in silence. The manager links that node into a queue kept in the directory. It records the newest waiter in a tail register and keeps one successor pointer per node.

When the holder sends a release, the manager reads the holder's successor pointer. It sends one grant message to that node alone. If the holder has no successor, the lock becomes free and the tail register is cleared. A release from any node other than the current holder produces a one-cycle error pulse and has no other effect. Each node is expected to have at most one acquire outstanding at a time.

Top module: `qlock_home`

## Requirements
- R1: After reset, no grant and no error pulse is issued, and the lock is free.
- R2: An acquire that arrives while the lock is free is granted on the next clock edge. The grant carries the requester's node number.
- R3: An acquire that arrives while the lock is held produces no grant. The requester is linked behind the current tail and becomes the new tail.
- R4: While nodes are only waiting and no acquire or release arrives, the manager issues no grant and no error.
- R5: A release by the holder when a successor exists grants exactly that successor on the next clock edge. The successor becomes the holder.
- R6: Waiting nodes receive the lock in strict order of acquire arrival.
- R7: A release by the holder with no successor frees the lock without any grant or error. A later acquire is then granted at once.
- R8: A release from a node that is not the holder, or a release while the lock is free, raises the error output for one cycle on the next edge. That release changes neither the holder nor the queue.
- R9: When an acquire and a release arrive in the same cycle, the release is applied first. If that release frees the lock, the acquirer is granted on the next edge. Otherwise the successor is granted and the acquirer is appended to the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| acq_valid_i | input | 1 | One-cycle acquire message |
| acq_node_i | input | NODE_W | Node number of the acquirer |
| rel_valid_i | input | 1 | One-cycle release message |
| rel_node_i | input | NODE_W | Node number of the releaser |
| grant_valid_o | output | 1 | One-cycle grant message |
| grant_node_o | output | NODE_W | Node number that now holds the lock |
| rel_err_o | output | 1 | One-cycle pulse for a release from a non-holder |

## Verification
Every result arrives exactly one clock edge after the message that causes it. This holds for a grant to a free-lock acquirer, a hand-off to a successor, and an error pulse. A queued acquire and an idle cycle produce nothing on that edge.

The bench drives each message on a falling edge and lets one rising edge pass. It compares the grant and error outputs at the following falling edge. It then removes the message, so each comparison covers the response to exactly one input cycle.

// File: rtl/qlock_pkg.sv
package qlock_pkg;
  typedef enum logic {
    LK_FREE = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;
endpackage

// File: rtl/qlock_rst_sync.sv
module qlock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/qlock_link_table.sv
module qlock_link_table #(
  parameter int NODES  = 8,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NODE_W-1:0] wr_idx,
  input  logic [NODE_W-1:0] wr_val,
  input  logic [NODE_W-1:0] rd_idx,
  output logic [NODE_W-1:0] rd_val
);
  logic [NODE_W-1:0] succ_q [NODES];

  for (genvar n = 0; n < NODES; n++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == NODE_W'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       succ_q[n] <= '0;
      else if (slot_en) succ_q[n] <= wr_val;
    end
  end

  assign rd_val = succ_q[rd_idx];
endmodule

// File: rtl/qlock_ctrl.sv
module qlock_ctrl
  import qlock_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_valid_i,
  input  logic [NODE_W-1:0] acq_node_i,
  input  logic              rel_valid_i,
  input  logic [NODE_W-1:0] rel_node_i,
  input  logic [NODE_W-1:0] succ_i,
  output logic [NODE_W-1:0] succ_rd_idx_o,
  output logic              link_wr_en_o,
  output logic [NODE_W-1:0] link_wr_idx_o,
  output logic [NODE_W-1:0] link_wr_val_o,
  output logic              grant_valid_o,
  output logic [NODE_W-1:0] grant_node_o,
  output logic              rel_err_o
);
  lock_state_e       st_q, st_d;
  logic [NODE_W-1:0] holder_q, holder_d;
  logic [NODE_W-1:0] tail_q, tail_d;
  logic              gv_q, gv_d;
  logic [NODE_W-1:0] gn_q, gn_d;
  logic              err_q, err_d;
  logic              rel_ok;
  logic              state_en;

  assign rel_ok        = rel_valid_i && (st_q == LK_HELD) && (rel_node_i == holder_q);
  assign succ_rd_idx_o = holder_q;
  assign state_en      = acq_valid_i || rel_valid_i;

  always_comb begin
    st_d          = st_q;
    holder_d      = holder_q;
    tail_d        = tail_q;
    gv_d          = 1'b0;
    gn_d          = gn_q;
    err_d         = rel_valid_i && !rel_ok;
    link_wr_en_o  = 1'b0;
    link_wr_idx_o = tail_q;
    link_wr_val_o = acq_node_i;
    // release first
    if (rel_ok) begin
      if (holder_q == tail_q) begin
        st_d   = LK_FREE;
        tail_d = '0;
      end else begin
        holder_d = succ_i;
        gv_d     = 1'b1;
        gn_d     = succ_i;
      end
    end
    // then acquire, against the post-release state
    if (acq_valid_i) begin
      if (st_d == LK_FREE) begin
        st_d     = LK_HELD;
        holder_d = acq_node_i;
        tail_d   = acq_node_i;
        gv_d     = 1'b1;
        gn_d     = acq_node_i;
      end else begin
        link_wr_en_o = 1'b1;
        tail_d       = acq_node_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LK_FREE;
      holder_q <= '0;
      tail_q   <= '0;
    end else if (state_en) begin
      st_q     <= st_d;
      holder_q <= holder_d;
      tail_q   <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q  <= 1'b0;
      gn_q  <= '0;
      err_q <= 1'b0;
    end else begin
      gv_q  <= gv_d;
      err_q <= err_d;
      if (gv_d) gn_q <= gn_d;
    end
  end

  assign grant_valid_o = gv_q;
  assign grant_node_o  = gn_q;
  assign rel_err_o     = err_q;

  AST_FREE_ACQ_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    acq_valid_i && st_q == LK_FREE |=> grant_valid_o && grant_node_o == $past(acq_node_i)); // R2
  AST_TAIL_FOLLOWS_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    acq_valid_i |=> tail_q == $past(acq_node_i)); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_valid_i && !rel_valid_i |=> !grant_valid_o && !rel_err_o && $stable(tail_q)); // R4
  AST_GRANT_IS_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> st_q == LK_HELD && holder_q == grant_node_o); // R5
  AST_LAST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid_i && !acq_valid_i && st_q == LK_HELD && rel_node_i == holder_q && holder_q == tail_q
    |=> st_q == LK_FREE && !grant_valid_o); // R7
  AST_BAD_RELEASE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid_i && !acq_valid_i && (st_q == LK_FREE || rel_node_i != holder_q)
    |=> rel_err_o && !grant_valid_o && $stable(holder_q) && $stable(tail_q) && $stable(st_q)); // R8
endmodule

// File: rtl/qlock_home.sv
module qlock_home #(
  parameter int NODES  = 8,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_valid_i,
  input  logic [NODE_W-1:0] acq_node_i,
  input  logic              rel_valid_i,
  input  logic [NODE_W-1:0] rel_node_i,
  output logic              grant_valid_o,
  output logic [NODE_W-1:0] grant_node_o,
  output logic              rel_err_o
);
  logic              rst_int_n;
  logic [NODE_W-1:0] succ;
  logic [NODE_W-1:0] succ_rd_idx;
  logic              link_wr_en;
  logic [NODE_W-1:0] link_wr_idx;
  logic [NODE_W-1:0] link_wr_val;

  qlock_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  qlock_link_table #(.NODES(NODES), .NODE_W(NODE_W)) u_links (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (link_wr_en),
    .wr_idx (link_wr_idx),
    .wr_val (link_wr_val),
    .rd_idx (succ_rd_idx),
    .rd_val (succ)
  );

  qlock_ctrl #(.NODES(NODES), .NODE_W(NODE_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .acq_valid_i   (acq_valid_i),
    .acq_node_i    (acq_node_i),
    .rel_valid_i   (rel_valid_i),
    .rel_node_i    (rel_node_i),
    .succ_i        (succ),
    .succ_rd_idx_o (succ_rd_idx),
    .link_wr_en_o  (link_wr_en),
    .link_wr_idx_o (link_wr_idx),
    .link_wr_val_o (link_wr_val),
    .grant_valid_o (grant_valid_o),
    .grant_node_o  (grant_node_o),
    .rel_err_o     (rel_err_o)
  );
endmodule

// File: tb/qlock_home_test.sv
`timescale 1ns/1ps
module qlock_home_test;
  localparam int NODES  = 8;
  localparam int NODE_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acq_valid_i;
  logic [NODE_W-1:0] acq_node_i;
  logic              rel_valid_i;
  logic [NODE_W-1:0] rel_node_i;
  logic              grant_valid_o;
  logic [NODE_W-1:0] grant_node_o;
  logic              rel_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  qlock_home #(.NODES(NODES), .NODE_W(NODE_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .acq_valid_i(acq_valid_i), .acq_node_i(acq_node_i),
    .rel_valid_i(rel_valid_i), .rel_node_i(rel_node_i),
    .grant_valid_o(grant_valid_o), .grant_node_o(grant_node_o),
    .rel_err_o(rel_err_o)
  );

  // Drive one message cycle, check the response one edge later.
  task automatic step(input bit av, input int an, input bit rv, input int rn,
                      input bit egv, input int egn, input bit eerr, input string tag);
    @(negedge clk);
    acq_valid_i = av; acq_node_i = NODE_W'(an);
    rel_valid_i = rv; rel_node_i = NODE_W'(rn);
    @(negedge clk);
    acq_valid_i = 1'b0; rel_valid_i = 1'b0;
    checks++;
    if (grant_valid_o !== egv || (egv && grant_node_o !== NODE_W'(egn)) || rel_err_o !== eerr) begin
      fails++;
      $display("FAIL %s: grant=%0b node=%0d err=%0b, expected grant=%0b node=%0d err=%0b",
               tag, grant_valid_o, grant_node_o, rel_err_o, egv, egn, eerr);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (grant_valid_o !== 1'b0 || rel_err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: grant=%0b err=%0b, expected grant=0 err=0", grant_valid_o, rel_err_o);
    end
    step(1, 3, 0, 0, 1, 3, 0, "R1 lock free after reset");
    step(0, 0, 1, 3, 0, 0, 0, "R1 cleanup release");
  endtask

  task automatic t_free();
    step(1, 5, 0, 0, 1, 5, 0, "R2 free acquire");
    step(0, 0, 1, 5, 0, 0, 0, "R7 last release frees");
    step(1, 0, 0, 0, 1, 0, 0, "R7 reacquire at once");
    step(0, 0, 1, 0, 0, 0, 0, "R7 release");
  endtask

  task automatic t_queue();
    step(1, 1, 0, 0, 1, 1, 0, "R2 holder 1");
    step(1, 4, 0, 0, 0, 0, 0, "R3 queue 4");
    step(1, 6, 0, 0, 0, 0, 0, "R3 queue 6");
    step(1, 2, 0, 0, 0, 0, 0, "R3 queue 2");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, "R4 silent wait");
    step(0, 0, 1, 1, 1, 4, 0, "R5 hand-off to 4");
    step(0, 0, 1, 4, 1, 6, 0, "R6 order 6");
    step(0, 0, 1, 6, 1, 2, 0, "R6 order 2");
    step(0, 0, 1, 2, 0, 0, 0, "R7 queue drained");
    step(1, 7, 0, 0, 1, 7, 0, "R7 acquire after drain");
    step(0, 0, 1, 7, 0, 0, 0, "R7 release 7");
  endtask

  task automatic t_badrel();
    step(0, 0, 1, 0, 0, 0, 1, "R8 release while free");
    step(1, 2, 0, 0, 1, 2, 0, "R8 holder 2");
    step(0, 0, 1, 5, 0, 0, 1, "R8 non-holder release");
    step(1, 3, 0, 0, 0, 0, 0, "R8 queue 3");
    step(0, 0, 1, 3, 0, 0, 1, "R8 waiter releases");
    step(0, 0, 1, 2, 1, 3, 0, "R8 queue intact");
    step(0, 0, 1, 3, 0, 0, 0, "R8 release 3");
  endtask

  task automatic t_same();
    step(1, 1, 0, 0, 1, 1, 0, "R9 holder 1");
    step(1, 6, 1, 1, 1, 6, 0, "R9 release frees, acquirer granted");
    step(1, 0, 0, 0, 0, 0, 0, "R9 queue 0");
    step(1, 5, 1, 6, 1, 0, 0, "R9 successor first, acquirer queued");
    step(0, 0, 1, 0, 1, 5, 0, "R9 appended acquirer served");
    step(0, 0, 1, 5, 0, 0, 0, "R9 drained");
  endtask

  initial begin
    rst_n = 1'b0; acq_valid_i = 1'b0; acq_node_i = '0;
    rel_valid_i = 1'b0; rel_node_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_free();
    t_queue();
    t_badrel();
    t_same();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule